// File: doc/BRIEF.md
# Serial ADC Host Channel Sequencer

This block sits on the system clock and runs the four-wire serial link to an external two-channel 12-bit successive-approximation converter. It makes the chip-select and serial clock itself. The serial clock comes from a divider whose half-period is given in system clocks. During each 16-clock conversion it shifts out a control byte that picks the channel for the following conversion. It shifts in the 12-bit straight-binary result and presents it on a one-cycle valid strobe. Each sample carries the channel it was actually taken from.

The converter applies a channel address one conversion late. The block therefore keeps the address it sent in the previous conversion and uses it to tag each result. This tag survives across frames, and after reset the first conversion is tagged channel 0. A start pulse either runs one conversion or opens a continuous frame. In a continuous frame chip-select stays low and conversions follow back to back, on one fixed channel or alternating between the two. A stop pulse closes a continuous frame at the next conversion boundary.

Top module: `adc_seq_host`

## Requirements
- R1: After reset cs_n is 1, sclk is 0, din is 0, busy is 0 and smp_valid is 0.
- R2: Each sclk half-period lasts div_half system clocks. div_half is taken at start, and values below 2 act as 2.
- R3: The first rising sclk edge of a frame comes exactly one half-period after cs_n falls, with sclk held low. cs_n rises only after a whole multiple of 16 rising sclk edges, and sclk is 0 whenever cs_n is 1.
- R4: In each conversion the control byte is presented MSB first, one bit per rising sclk edge on rising edges 1 to 8. Bit 3 holds the requested channel and every other bit is 0, so bit 4 is never set. din changes only while sclk is low.
- R5: dout is sampled on rising edges 5 to 16 of each conversion, MSB first, and forms the 12-bit result on smp_data.
- R6: smp_ch is the channel address sent during the previous conversion, even if that conversion was in an earlier frame. The first conversion after reset is tagged 0.
- R7: With cfg_cont at 0, a start pulse runs exactly one conversion and then raises cs_n.
- R8: With cfg_cont at 1, cs_n stays low and conversions follow each other every 16 sclk periods until a stop is taken.
- R9: With cfg_alt at 1, the address sent is the inverse of the current conversion's channel. With cfg_alt at 0, it is cfg_ch.
- R10: A stop pulse during a frame ends it after the conversion that is in progress. A stop in the same system cycle as the 16th falling sclk edge ends the frame at that boundary. The frame then holds sclk low for one half-period and raises cs_n. A stop while idle and a start while busy have no effect.
- R11: Every conversion yields exactly one single-cycle smp_valid pulse, issued while sclk is high after the 16th rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Pulse that opens a frame when idle |
| stop | input | 1 | Pulse that closes a running frame at a conversion boundary |
| cfg_cont | input | 1 | 1: continuous frame, 0: single conversion |
| cfg_alt | input | 1 | 1: alternate channels, 0: use cfg_ch |
| cfg_ch | input | 1 | Fixed channel request |
| div_half | input | DIVW | System clocks per sclk half-period |
| sclk | output | 1 | Serial clock to converter |
| cs_n | output | 1 | Active-low chip select |
| din | output | 1 | Control bits to converter |
| dout | input | 1 | Result bits from converter |
| busy | output | 1 | Frame in progress |
| smp_valid | output | 1 | One-cycle result strobe |
| smp_data | output | DW | Conversion result |
| smp_ch | output | 1 | Channel the result was taken from |

## Verification
A stop request and the conversion boundary, meaning the 16th falling sclk edge, can land in the same system cycle. The bench counts system cycles from the last result strobe so that stop is sampled exactly on that edge, and in another run one cycle later. The same-cycle stop must close the frame after k conversions, and the late stop after k+1. Both the result count and the rising edges per frame are compared against that expectation, and a behavioural converter model returns fixed per-channel values so that the channel tags can be judged as well.

// File: rtl/adc_seq_host.sv
module adc_seq_host #(
  parameter int DIVW  = 8,
  parameter int DW    = 12,
  parameter int SLOTS = 16,
  parameter int CBITS = 8,
  parameter int ADDR_BIT = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            stop,
  input  logic            cfg_cont,
  input  logic            cfg_alt,
  input  logic            cfg_ch,
  input  logic [DIVW-1:0] div_half,
  output logic            sclk,
  output logic            cs_n,
  output logic            din,
  input  logic            dout,
  output logic            busy,
  output logic            smp_valid,
  output logic [DW-1:0]   smp_data,
  output logic            smp_ch
);
  localparam int EW = $clog2(SLOTS + 1);
  localparam logic [EW-1:0] FIRST_DATA = EW'(SLOTS - DW);
  localparam logic [EW-1:0] LAST_EDGE  = EW'(SLOTS);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_TAIL} st_t;

  st_t             st_q;
  logic [DIVW-1:0] cnt_q, half_q;
  logic [EW-1:0]   edge_q;
  logic [CBITS-1:0] ctl_q;
  logic [DW-1:0]   sh_q;
  logic            cont_q, alt_q, fix_q, stop_q;
  logic            cur_ch_q, pend_ch_q;

  function automatic logic [CBITS-1:0] mk_ctl(input logic ch);
    logic [CBITS-1:0] b;
    b = '0;
    b[ADDR_BIT] = ch;
    return b;
  endfunction

  wire [DIVW-1:0] half_eff = (div_half < DIVW'(2)) ? DIVW'(2) : div_half;
  wire tick   = (cnt_q == half_q - DIVW'(1));
  wire run    = (st_q == S_RUN);
  wire rise   = run && !sclk && tick;
  wire fall   = run && sclk && tick;
  wire last   = (edge_q == LAST_EDGE);
  wire close  = !cont_q || stop_q || stop;
  wire na_go  = cfg_alt ? ~cur_ch_q : cfg_ch;
  wire na_run = alt_q ? ~cur_ch_q : fix_q;

  assign din  = ctl_q[CBITS-1];
  assign busy = (st_q != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE;
      cnt_q <= '0;
      half_q <= DIVW'(2);
      edge_q <= '0;
      ctl_q <= '0;
      sh_q <= '0;
      cont_q <= 1'b0;
      alt_q <= 1'b0;
      fix_q <= 1'b0;
      stop_q <= 1'b0;
      cur_ch_q <= 1'b0;
      pend_ch_q <= 1'b0;
      sclk <= 1'b0;
      cs_n <= 1'b1;
      smp_valid <= 1'b0;
      smp_data <= '0;
      smp_ch <= 1'b0;
    end else begin
      smp_valid <= 1'b0;
      case (st_q)
        S_IDLE: begin
          if (start) begin
            st_q <= S_RUN;
            cs_n <= 1'b0;
            sclk <= 1'b0;
            cnt_q <= '0;
            edge_q <= '0;
            half_q <= half_eff;
            cont_q <= cfg_cont;
            alt_q <= cfg_alt;
            fix_q <= cfg_ch;
            stop_q <= 1'b0;
            ctl_q <= mk_ctl(na_go);
            pend_ch_q <= na_go;
          end
        end
        S_RUN: begin
          cnt_q <= tick ? '0 : cnt_q + DIVW'(1);
          if (stop) stop_q <= 1'b1;
          if (rise) begin
            sclk <= 1'b1;
            edge_q <= edge_q + EW'(1);
            if (edge_q >= FIRST_DATA) sh_q <= {sh_q[DW-2:0], dout};
            if (edge_q == LAST_EDGE - EW'(1)) begin
              smp_valid <= 1'b1;
              smp_data <= {sh_q[DW-2:0], dout};
              smp_ch <= cur_ch_q;
              cur_ch_q <= pend_ch_q;
            end
          end
          if (fall) begin
            sclk <= 1'b0;
            if (last) begin
              if (close) begin
                st_q <= S_TAIL;
                ctl_q <= '0;
              end else begin
                edge_q <= '0;
                ctl_q <= mk_ctl(na_run);
                pend_ch_q <= na_run;
              end
            end else begin
              ctl_q <= {ctl_q[CBITS-2:0], 1'b0};
            end
          end
        end
        S_TAIL: begin
          cnt_q <= tick ? '0 : cnt_q + DIVW'(1);
          if (tick) begin
            st_q <= S_IDLE;
            cs_n <= 1'b1;
            edge_q <= '0;
            stop_q <= 1'b0;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  p_park_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);
  p_lead_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> !sclk);
  p_whole_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> $past(edge_q) == LAST_EDGE);
  p_min_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk) |-> $past(sclk, 2));
  p_min_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> !$past(sclk, 2));
  p_add1_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && edge_q == EW'(3)) |-> !din);
  p_din_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(din));
  p_valid_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |=> !smp_valid);
  p_valid_in_frame_r11: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |-> (sclk && !cs_n));
endmodule

// File: tb/adc_seq_host_tb.sv
module adc_seq_host_tb;
  logic clk = 0, rst_n = 0;
  logic start = 0, stop = 0, cfg_cont = 0, cfg_alt = 0, cfg_ch = 0;
  logic [7:0] div_half = 8'd4;
  logic sclk, cs_n, din, busy, smp_valid, smp_ch;
  logic dout = 0;
  logic [11:0] smp_data;

  int checks = 0, errors = 0;
  logic [11:0] ain [2];
  logic [11:0] q_data[$];
  logic        q_ch[$];
  logic [7:0]  q_byte[$];
  logic        exp_cur = 0;
  int exp_half = 2, exp_edges = 16;

  always #2 clk = ~clk;

  adc_seq_host u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .stop(stop),
    .cfg_cont(cfg_cont), .cfg_alt(cfg_alt), .cfg_ch(cfg_ch), .div_half(div_half),
    .sclk(sclk), .cs_n(cs_n), .din(din), .dout(dout), .busy(busy),
    .smp_valid(smp_valid), .smp_data(smp_data), .smp_ch(smp_ch));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural converter
  int rc = 0;
  logic [7:0]  mbyte = 0;
  logic [11:0] msamp = 0;
  logic        mch = 0;
  always @(negedge cs_n) begin rc = 0; dout = 0; end
  always @(posedge sclk) if (!cs_n) begin
    rc++;
    if (rc == 1) msamp = ain[mch];
    if (rc <= 8) mbyte = {mbyte[6:0], din};
    if (rc == 8) begin
      if (q_byte.size() == 0) chk(0, "R4 unexpected byte", mbyte, 0);
      else begin
        logic [7:0] eb;
        eb = q_byte.pop_front();
        chk(mbyte == eb, "R4/R9 control byte", mbyte, eb);
      end
    end
    if (rc == 16) begin mch = mbyte[3]; rc = 0; end
  end
  always @(negedge sclk) if (!cs_n) begin
    int slot;
    slot = rc + 1;
    dout = (slot >= 5 && slot <= 16) ? msamp[16 - slot] : 1'b0;
  end

  // scoreboard monitor
  always @(negedge clk) if (rst_n && smp_valid) begin
    if (q_data.size() == 0) chk(0, "R11 extra sample", smp_data, 0);
    else begin
      logic [11:0] ed;
      logic ec;
      ed = q_data.pop_front();
      ec = q_ch.pop_front();
      chk(smp_ch == ec, "R6/R9 channel tag", smp_ch, ec);
      chk(smp_data == ed, "R5 sample data", smp_data, ed);
    end
  end

  // frame monitor
  logic p_cs = 1, p_sclk = 0, p_din = 0;
  int lead = 0, edges = 0, since = 0;
  always @(negedge clk) if (rst_n) begin
    if (!cs_n) begin lead++; since++; end
    if (p_cs && !cs_n) begin lead = 0; edges = 0; since = 0; end
    if (!p_sclk && sclk) begin
      if (edges == 0) chk(lead == exp_half, "R3 lead half-period", lead, exp_half);
      else if ((edges % 16) != 0)
        chk(since == 2 * exp_half, "R2 sclk period", since, 2 * exp_half);
      edges++;
      since = 0;
    end
    if (p_sclk && sclk && din != p_din) chk(0, "R4 din moved with sclk high", din, p_din);
    if (!p_cs && cs_n) begin
      chk(edges == exp_edges, "R3/R8 rising edges per frame", edges, exp_edges);
      chk(sclk == 0, "R3 sclk parked", sclk, 0);
    end
    p_cs = cs_n; p_sclk = sclk; p_din = din;
  end

  task automatic run(input int k, input bit cont, input bit alt, input bit ch,
                     input int d, input bit late, input bit dbl_start);
    int m, seen;
    m = cont ? (late ? k + 1 : k) : 1;
    for (int i = 0; i < m; i++) begin
      logic a;
      a = alt ? ~exp_cur : ch;
      q_ch.push_back(exp_cur);
      q_data.push_back(ain[exp_cur]);
      q_byte.push_back(8'(a) << 3);
      exp_cur = a;
    end
    exp_half = (d < 2) ? 2 : d;
    exp_edges = 16 * m;
    @(negedge clk);
    cfg_cont = cont; cfg_alt = alt; cfg_ch = ch; div_half = 8'(d); start = 1;
    @(negedge clk);
    start = 0;
    if (dbl_start) begin
      repeat (20) @(negedge clk);
      start = 1;
      @(negedge clk);
      start = 0;
    end
    if (cont) begin
      seen = 0;
      while (seen < k) begin
        @(negedge clk);
        if (smp_valid) seen++;
      end
      repeat (exp_half - 1) @(negedge clk);
      if (late) @(negedge clk);
      stop = 1;
      @(negedge clk);
      stop = 0;
    end
    while (busy) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(q_data.size() == 0, "R7/R10/R11 samples outstanding", q_data.size(), 0);
    chk(cs_n == 1, "R7/R10 cs_n high after frame", cs_n, 1);
  endtask

  bit done = 0;
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    ain[0] = 12'h8A5; ain[1] = 12'h35A;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(cs_n == 1, "R1 cs_n", cs_n, 1);
    chk(sclk == 0, "R1 sclk", sclk, 0);
    chk(din == 0, "R1 din", din, 0);
    chk(busy == 0, "R1 busy", busy, 0);
    chk(smp_valid == 0, "R1 smp_valid", smp_valid, 0);
    // R7 single, R6 first conversion tagged 0
    run(1, 0, 0, 1, 3, 0, 0);
    // R6 tag persists across frames
    run(1, 0, 0, 0, 2, 0, 0);
    // R8/R9 continuous alternate, full-scale values
    ain[0] = 12'hFFF; ain[1] = 12'h000;
    run(5, 1, 1, 0, 4, 0, 0);
    // R10 late stop gives one extra conversion
    ain[0] = 12'h0F0; ain[1] = 12'hC3C;
    run(3, 1, 0, 1, 5, 1, 0);
    // R10 stop while idle ignored; R2 clamp of div_half 1
    @(negedge clk); stop = 1; @(negedge clk); stop = 0;
    run(3, 1, 0, 0, 1, 0, 0);
    // R10 start while busy ignored; R2 clamp of div_half 0
    ain[0] = 12'h001; ain[1] = 12'h800;
    run(1, 0, 0, 1, 0, 0, 1);
    // R10 stop at very first boundary
    run(1, 1, 1, 0, 2, 0, 0);
    // R9 alternate in single mode
    run(1, 0, 1, 0, 3, 0, 0);
    chk(q_byte.size() == 0, "R4 bytes outstanding", q_byte.size(), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule